// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block holds the digital dividers of an integer-N frequency synthesizer that drives an external dual-modulus prescaler. The prescaler divides the oscillator by 32 or by 33, and the block decides which. A division ratio N of 14 bits reaches the block as a 9-bit main count M and a 5-bit swallow count A, where N = 32·M + A. One division cycle lasts M prescaler-output cycles. The prescaler runs at divide-by-33 for the first A of them and at divide-by-32 for the others. The net result is one divided tick per N oscillator cycles. For example, M = 287 and A = 2 give N = 9186.

In a second clock domain, a counter divides the crystal clock by 2^REF_W (4096 by default) to make the comparison tick. The divided tick is carried into the crystal domain. At every reference tick it is compared in time against that tick. A lock flag goes high after a run of close matches and drops at the first poor match. A ratio flag reports that the loaded M is smaller than A, because then the prescaler cannot swallow enough pulses. The phase detector, charge pump and loop filter are outside the block.

Top module: `swallow_synth_div`

## Requirements
- R1: `ref_tick` is high for exactly one crystal cycle in every 2^REF_W crystal cycles, with no other output or input affecting its period.
- R2: A division cycle lasts M rising edges of `pre_clk` (M being the loaded main count, 1 to 511), and `div_tick` is high only in the last of them.
- R3: `mod33` = 1 selects divide-by-33 and `mod33` = 0 selects divide-by-32. Within a cycle with A ≤ M, `mod33` is 1 for the first A prescaler-output cycles and 0 for the rest, so the cycle spans 32·M + A oscillator cycles.
- R4: `m_in` and `a_in` are sampled only on the `pre_clk` edge that ends a cycle (`div_tick` high) and govern the following cycle. A change in the middle of a cycle does not alter that cycle's length or modulus pattern.
- R5: `ratio_bad` reads 1 throughout a cycle whose loaded M is less than its loaded A, and 0 when M ≥ A (including M = A).
- R6: While `rst_n` is low, every output is 0. The first `pre_clk` edge after reset loads `m_in` and `a_in` and begins a cycle without raising `div_tick`.
- R7: A comparison takes place at every reference tick. It counts as a match if the divided tick, after a two-flop crossing into the crystal domain, occurs within WIN crystal cycles (default 2) on either side of the reference tick. Otherwise it counts as a miss, which is decided WIN cycles after the tick.
- R8: `lock` rises one crystal cycle after the LOCK_N-th consecutive match (default 16) and not earlier.
- R9: `lock` falls one crystal cycle after any miss, and the run of matches restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal-derived reference clock |
| pre_clk | input | 1 | Output of the external dual-modulus prescaler |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| m_in | input | 9 | Main count M |
| a_in | input | 5 | Swallow count A |
| mod33 | output | 1 | Prescaler modulus select, 1 = divide by 33 |
| div_tick | output | 1 | Divided tick, one `pre_clk` cycle per division cycle |
| ref_tick | output | 1 | Reference comparison tick, one `xtal_clk` cycle wide |
| ratio_bad | output | 1 | The loaded M is less than the loaded A |
| lock | output | 1 | The divided and reference ticks agree in time |

## Verification
A wrong cycle counter or a load at the wrong moment shows up in the same cycle as a wrong distance between `div_tick` pulses. A swallow counter off by one shows up as one `mod33` cycle too many or too few, and so as a wrong oscillator count for that cycle. Faults in the lock path are slower to surface, because `lock` responds only at reference ticks: an error in the match counter changes the time `lock` rises by whole reference periods, and a miss that is not acted on leaves `lock` high for a full reference period or longer after the tick frequencies have moved apart. For this reason the bench places the lock checks at fixed reference periods counted from reset, and it sweeps every (M, A) pair up to M = 24, plus the extreme counts.

// File: rtl/swallow_synth_div.sv
module swallow_synth_div #(
  parameter int M_W    = 9,
  parameter int A_W    = 5,
  parameter int REF_W  = 12,
  parameter int LOCK_N = 16,
  parameter int WIN    = 2
) (
  input  logic           xtal_clk,
  input  logic           pre_clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  output logic           mod33,
  output logic           div_tick,
  output logic           ref_tick,
  output logic           ratio_bad,
  output logic           lock
);

  localparam int HW = $clog2(LOCK_N + 1);
  localparam int PW = $clog2(WIN + 1);

  // prescaler-output domain
  logic [M_W-1:0] left;
  logic [A_W-1:0] sw;
  logic           started;
  logic           bad_q;
  logic           tgl;

  assign div_tick  = started && (left == '0);
  assign mod33     = started && (sw != '0);
  assign ratio_bad = bad_q;

  always_ff @(posedge pre_clk or negedge rst_n) begin
    if (!rst_n) begin
      left    <= '0;
      sw      <= '0;
      started <= 1'b0;
      bad_q   <= 1'b0;
      tgl     <= 1'b0;
    end else if (!started || left == '0) begin
      started <= 1'b1;
      left    <= m_in - M_W'(1);
      sw      <= a_in;
      bad_q   <= (m_in < M_W'(a_in));
      tgl     <= tgl ^ started;
    end else begin
      left <= left - M_W'(1);
      if (sw != '0) sw <= sw - A_W'(1);
    end
  end

  // crystal domain: reference divider
  logic [REF_W-1:0] rcnt;

  assign ref_tick = (rcnt == '1);

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) rcnt <= '0;
    else        rcnt <= rcnt + REF_W'(1);
  end

  // crystal domain: divided tick crossing
  logic [2:0] sy;
  logic       div_evt;

  assign div_evt = sy[2] ^ sy[1];

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], tgl};
  end

  // crystal domain: comparison window
  logic [WIN-1:0] hist;
  logic [PW-1:0]  pend;
  logic           recent;
  logic           cmp_hit;
  logic           cmp_miss;

  assign recent   = div_evt || (hist != '0);
  assign cmp_hit  = (ref_tick && recent) || ((pend != '0) && div_evt);
  assign cmp_miss = (pend == PW'(1)) && !div_evt;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      pend <= '0;
    end else begin
      hist <= {hist[WIN-2:0], div_evt};
      if (ref_tick && !recent)            pend <= PW'(WIN);
      else if (pend != '0 && div_evt)     pend <= '0;
      else if (pend != '0)                pend <= pend - PW'(1);
    end
  end

  // crystal domain: lock qualification
  logic [HW-1:0] hits;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      hits <= '0;
      lock <= 1'b0;
    end else if (cmp_miss) begin
      hits <= '0;
      lock <= 1'b0;
    end else if (cmp_hit) begin
      if (hits == HW'(LOCK_N - 1)) lock <= 1'b1;
      if (hits != HW'(LOCK_N))     hits <= hits + HW'(1);
    end
  end

endmodule

// File: rtl/swallow_synth_div_chk.sv
module swallow_synth_div_chk #(
  parameter int M_W    = 9,
  parameter int A_W    = 5,
  parameter int LOCK_N = 16,
  parameter int HW     = 5
) (
  input logic           xtal_clk,
  input logic           pre_clk,
  input logic           rst_n,
  input logic [M_W-1:0] m_in,
  input logic [A_W-1:0] a_in,
  input logic           mod33,
  input logic           div_tick,
  input logic           ref_tick,
  input logic           ratio_bad,
  input logic           lock,
  input logic           started,
  input logic [HW-1:0]  hits,
  input logic           cmp_hit,
  input logic           cmp_miss
);

  // R1
  ref_single_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);

  // R3
  swallow_start_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    div_tick |=> (mod33 == ($past(a_in) != '0)));

  // R3
  mod_rise_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    $rose(mod33) |-> ($past(div_tick) || !$past(started)));

  // R5
  ratio_flag_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    div_tick |=> (ratio_bad == ($past(m_in) < M_W'($past(a_in)))));

  // R8
  lock_rise_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(cmp_hit) && ($past(hits) == HW'(LOCK_N - 1))));

  // R9
  lock_drop_chk: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    cmp_miss |=> !lock);

endmodule

bind swallow_synth_div swallow_synth_div_chk #(
  .M_W(M_W), .A_W(A_W), .LOCK_N(LOCK_N), .HW(HW)
) u_chk (
  .xtal_clk(xtal_clk), .pre_clk(pre_clk), .rst_n(rst_n),
  .m_in(m_in), .a_in(a_in), .mod33(mod33), .div_tick(div_tick),
  .ref_tick(ref_tick), .ratio_bad(ratio_bad), .lock(lock),
  .started(started), .hits(hits), .cmp_hit(cmp_hit), .cmp_miss(cmp_miss)
);

// File: tb/test_swallow_synth_div.sv
module test_swallow_synth_div;
  logic       xtal_clk, pre_clk, rst_n;
  logic [8:0] m_in;
  logic [4:0] a_in;
  logic       mod33, div_tick, ref_tick, ratio_bad, lock;
  int errors = 0;
  int checks = 0;

  swallow_synth_div #(.REF_W(6)) i_swallow_synth_div (
    .xtal_clk(xtal_clk), .pre_clk(pre_clk), .rst_n(rst_n),
    .m_in(m_in), .a_in(a_in), .mod33(mod33), .div_tick(div_tick),
    .ref_tick(ref_tick), .ratio_bad(ratio_bad), .lock(lock)
  );

  initial begin
    xtal_clk = 0;
    forever #10 xtal_clk = ~xtal_clk;
  end

  initial begin
    pre_clk = 0;
    #1280;
    forever #40 pre_clk = ~pre_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cycle(input int a, output int len, output int ones, output bit pat_ok);
    len = 0; ones = 0; pat_ok = 1;
    do begin
      @(negedge pre_clk);
      if (mod33) ones++;
      if (mod33 != (len < a)) pat_ok = 0;
      len++;
    end while (!div_tick && len < 1000);
  endtask

  task automatic point(input int m, input int a);
    int len, ones;
    bit ok;
    m_in = 9'(m); a_in = 5'(a);
    run_cycle(a, len, ones, ok);
    chk(len == m, "R2 cycle length", len, m);
    chk(ok, "R3 modulus pattern", ones, a);
    chk(32 * len + ones == 32 * m + a, "R3 total ratio", 32 * len + ones, 32 * m + a);
    chk(ratio_bad == 1'b0, "R5 flag low for M>=A", int'(ratio_bad), 0);
  endtask

  initial begin
    int len, ones, n;
    bit ok;
    rst_n = 0; m_in = 9'd16; a_in = 5'd3;
    #50;
    chk({mod33, div_tick, ref_tick, ratio_bad, lock} == 5'b0, "R6 reset outputs",
        int'({mod33, div_tick, ref_tick, ratio_bad, lock}), 0);
    #55 rst_n = 1;
    #(1360 - 105);
    chk(mod33 == 1'b1 && div_tick == 1'b0, "R6 first edge loads", int'({mod33, div_tick}), 2);
    // matched periods: 16 matches needed, the first at the second reference tick
    #(21200 - 1360);
    chk(lock == 1'b0, "R8 lock not before 16th match", int'(lock), 0);
    #(22500 - 21200);
    chk(lock == 1'b1, "R8 lock after 16 matches (R7 window)", int'(lock), 1);
    m_in = 9'd17;
    #(6 * 1280);
    chk(lock == 1'b0, "R9 lock drops on drift", int'(lock), 0);
    #(10 * 1280);
    chk(lock == 1'b0, "R9 lock stays low while drifting", int'(lock), 0);

    // R1 reference period
    do @(negedge xtal_clk); while (!ref_tick);
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin @(negedge xtal_clk); n++; end while (!ref_tick && n < 200);
      chk(n == 64, "R1 reference period", n, 64);
    end

    // align to a cycle end
    do @(negedge pre_clk); while (!div_tick);
    for (int m = 1; m <= 24; m++)
      for (int a = 0; a <= m && a < 32; a++)
        point(m, a);
    point(287, 2);
    point(511, 31);
    point(31, 31);
    point(32, 0);

    // R4 mid-cycle change
    m_in = 9'd10; a_in = 5'd3;
    run_cycle(3, len, ones, ok);
    len = 0; ones = 0; ok = 1;
    do begin
      @(negedge pre_clk);
      if (mod33) ones++;
      if (mod33 != (len < 3)) ok = 0;
      len++;
      if (len == 4) begin m_in = 9'd5; a_in = 5'd1; end
    end while (!div_tick && len < 1000);
    chk(len == 10, "R4 running cycle length kept", len, 10);
    chk(ok && ones == 3, "R4 running pattern kept", ones, 3);
    run_cycle(1, len, ones, ok);
    chk(len == 5 && ones == 1, "R4 new values next cycle", 32 * len + ones, 161);

    // R5 invalid ratio and boundary M == A
    m_in = 9'd3; a_in = 5'd5;
    run_cycle(5, len, ones, ok);
    chk(ratio_bad == 1'b1, "R5 flag for M<A", int'(ratio_bad), 1);
    m_in = 9'd5; a_in = 5'd5;
    run_cycle(5, len, ones, ok);
    chk(ratio_bad == 1'b0, "R5 flag clear at M=A", int'(ratio_bad), 0);
    chk(len == 5 && ones == 5 && ok, "R3 all divide-by-33 at M=A", ones, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge xtal_clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule